// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

One pulse-width channel built around a down-counter. Software-visible period and compare values are written into holding buffers. They reach the live counter and the live compare register only at two moments: while a load strobe is held, or when the counter runs out with re-arm enabled. The output pin compares the live count against the live compare value. A one-cycle interrupt pulse marks each expiry. A prescaler outside the block supplies the tick enable, and the counter moves only on ticks.

The channel reads its four control bits out of a shared control word. The bits are run, load, flip and re-arm. The position of its field depends on the slot the channel occupies, and the last slot uses its own bit arrangement. If re-arm is cleared while the channel is running, the current period finishes and the channel then parks. It stays parked until the next load strobe.

Top module: `pwm_buffered_chan`

## Requirements
- R1: With a period buffer value N and a tick on every cycle, the counter steps N, N-1, ... 0, so one period lasts N+1 ticks. Each expiry raises `period_irq` for exactly one cycle, in the cycle after the tick that found the count at zero.
- R2: A write to a buffer lands in the buffer one cycle later. It changes neither the live count, the live compare nor the pin until a load or a re-arm transfer takes place.
- R3: In every cycle where the load bit is high, both buffers are copied into the live registers and a parked channel is released. Counting is suspended in those cycles.
- R4: When the count is zero on a tick and re-arm is set, the live count and the live compare are reloaded from the buffers.
- R5: When the count is zero on a tick and re-arm is clear, the channel parks. The count stays at zero, the pin holds its level, and no further interrupts occur until a load.
- R6: Without flip, the pin is low while count > compare and high while count <= compare.
- R7: A live compare of all ones keeps the channel in its low (duty) phase for the whole period. With flip set it is high instead.
- R8: Setting the flip bit inverts the pin.
- R9: The counter changes only on cycles where `tick_en` and the run bit are both high.
- R10: The control field of slot s starts at bit 0 when s is 0, and at bit 4*(s+1) otherwise. Within the field, run is at offset 0, load at offset 1, flip at offset 2 and re-arm at offset 3. All other control bits have no effect on the channel.
- R11: In the last slot (slot 4, field at bits 20..23), re-arm sits at offset 2. That slot has no flip function, so offset 3 has no effect.
- R12: After reset the buffers, the count and the compare are zero, `period_irq` is low and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable from an external prescaler |
| cnt_buf_we | input | 1 | Write strobe for the period buffer |
| cnt_buf_wdata | input | CNT_W | Period buffer data (ticks minus one) |
| cmp_buf_we | input | 1 | Write strobe for the compare buffer |
| cmp_buf_wdata | input | CNT_W | Compare buffer data |
| ctrl_word | input | CTRL_W | Shared control word holding every slot's field |
| pwm_pin | output | 1 | PWM output |
| period_irq | output | 1 | One-cycle pulse per counter expiry |

## Verification
The assertions assume that the control word and the write buses change only between clock edges, and that each write strobe comes with valid data in the same cycle. They also assume the load bit is a level that software raises and lowers, so copying in every cycle it is held is legitimate behaviour. The stimulus drives every input on the falling edge. It holds load for exactly one cycle, except in the case that deliberately holds it longer to show that counting is suspended. It sets or clears re-arm only while run is stable.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int SLOT_COUNT = 5;
  localparam int FIELD_W    = 4;
  localparam int LAST_SLOT  = SLOT_COUNT - 1;

  typedef struct packed {
    logic run;
    logic load;
    logic flip;
    logic rearm;
  } chan_ctl_t;

  // Field base: slot 0 at bit 0, then a one-field gap before slot 1.
  function automatic int slot_base(input int slot);
    return (slot == 0) ? 0 : FIELD_W * (slot + 1);
  endfunction

  function automatic int rearm_offset(input int slot);
    return (slot == LAST_SLOT) ? 2 : 3;
  endfunction

  function automatic bit slot_has_flip(input int slot);
    return slot != LAST_SLOT;
  endfunction

  function automatic int ctrl_width(input int slots);
    return FIELD_W * (slots + 1);
  endfunction

endpackage

// File: rtl/pwm_ctl_decode.sv
module pwm_ctl_decode import pwm_chan_pkg::*; #(
  parameter int CH_SLOT = 1,
  parameter int CTRL_W  = ctrl_width(SLOT_COUNT)
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  output chan_ctl_t         ctl
);

  localparam int BASE     = slot_base(CH_SLOT);
  localparam int RUN_POS  = BASE;
  localparam int LOAD_POS = BASE + 1;
  localparam int RARM_POS = BASE + rearm_offset(CH_SLOT);

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl_word;

  assign ctl.run   = ctrl_word[RUN_POS];
  assign ctl.load  = ctrl_word[LOAD_POS];
  assign ctl.rearm = ctrl_word[RARM_POS];

  generate
    if (slot_has_flip(CH_SLOT)) begin : g_flip
      localparam int FLIP_POS = BASE + 2;
      assign ctl.flip = ctrl_word[FLIP_POS];
    end else begin : g_no_flip
      assign ctl.flip = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cnt_buf,
  output logic [CNT_W-1:0] cmp_buf
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_buf <= '0;
      cmp_buf <= '0;
    end else begin
      if (cnt_we) cnt_buf <= cnt_wdata;
      if (cmp_we) cmp_buf <= cmp_wdata;
    end
  end

  // R2: writes land in the holding buffers one cycle later
  assert_buf_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_buf == $past(cnt_wdata)));
  assert_cmp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (cmp_buf == $past(cmp_wdata)));

endmodule

// File: rtl/pwm_down_core.sv
module pwm_down_core import pwm_chan_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  chan_ctl_t        ctl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cmp_nxt,
  output logic             step_ev,
  output logic             halted_q,
  output logic             irq_q
);

  // Named internal events
  logic live_ev, expire_ev, adv_ev, reload_ev, halt_ev, manual_ev, load_ev;

  assign manual_ev = ctl.load;
  assign live_ev   = tick_en && ctl.run && !ctl.load && !halted_q;
  assign expire_ev = live_ev && (cnt_q == '0);
  assign adv_ev    = live_ev && (cnt_q != '0);
  assign reload_ev = expire_ev && ctl.rearm;
  assign halt_ev   = expire_ev && !ctl.rearm;
  assign load_ev   = manual_ev || reload_ev;
  assign step_ev   = load_ev || adv_ev;

  always_comb begin
    cnt_nxt = cnt_q;
    cmp_nxt = cmp_q;
    if (load_ev) begin
      cnt_nxt = cnt_buf;
      cmp_nxt = cmp_buf;
    end else if (adv_ev) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmp_q    <= '0;
      halted_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      cmp_q <= cmp_nxt;
      if (manual_ev)    halted_q <= 1'b0;
      else if (halt_ev) halted_q <= 1'b1;
      irq_q <= expire_ev;
    end
  end

  // R1: a running tick with non-zero count steps down by one
  assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctl.run && !ctl.load && !halted_q && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R1: the interrupt follows a tick at count zero
  assert_irq_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(cnt_q) == '0));
  // R3: load copies both buffers and releases a parked channel
  assert_manual_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf) && !halted_q));
  // R4: expiry with re-arm reloads from the buffers
  assert_rearm_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rearm && tick_en && ctl.run && !ctl.load && !halted_q && cnt_q == '0)
      |=> (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf)));
  // R5: a parked channel keeps its state until a load
  assert_parked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !ctl.load) |=> ($stable(cnt_q) && $stable(cmp_q) && !irq_q));
  // R9: no tick or no run means no movement
  assert_gated_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_en && ctl.run) && !ctl.load) |=> ($stable(cnt_q) && $stable(cmp_q)));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_ev,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_nxt,
  input  logic             flip,
  output logic             phase_q,
  output logic             pin
);

  localparam logic [CNT_W-1:0] FULL = '1;

  // Duty phase: count above compare, or compare saturated.
  function automatic logic in_duty(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return (m == FULL) || (c > m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (step_ev) phase_q <= in_duty(cnt_nxt, cmp_nxt);
  end

  assign pin = flip ? phase_q : ~phase_q;

  // R5: without an update event the phase does not move
  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_ev |=> $stable(phase_q));

endmodule

// File: rtl/pwm_buffered_chan.sv
module pwm_buffered_chan import pwm_chan_pkg::*; #(
  parameter int CNT_W   = 16,
  parameter int CH_SLOT = 1,
  parameter int CTRL_W  = ctrl_width(SLOT_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_buf_we,
  input  logic [CNT_W-1:0]  cnt_buf_wdata,
  input  logic              cmp_buf_we,
  input  logic [CNT_W-1:0]  cmp_buf_wdata,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              pwm_pin,
  output logic              period_irq
);

  chan_ctl_t        ctl;
  logic [CNT_W-1:0] cnt_buf, cmp_buf;
  logic [CNT_W-1:0] cnt_act, cmp_act, cnt_nxt, cmp_nxt;
  logic             step_ev, halted, phase;

  pwm_ctl_decode #(.CH_SLOT(CH_SLOT), .CTRL_W(CTRL_W)) u_dec (
    .ctrl_word (ctrl_word),
    .ctl       (ctl)
  );

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_buf_we),
    .cnt_wdata (cnt_buf_wdata),
    .cmp_we    (cmp_buf_we),
    .cmp_wdata (cmp_buf_wdata),
    .cnt_buf   (cnt_buf),
    .cmp_buf   (cmp_buf)
  );

  pwm_down_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ctl      (ctl),
    .cnt_buf  (cnt_buf),
    .cmp_buf  (cmp_buf),
    .cnt_q    (cnt_act),
    .cmp_q    (cmp_act),
    .cnt_nxt  (cnt_nxt),
    .cmp_nxt  (cmp_nxt),
    .step_ev  (step_ev),
    .halted_q (halted),
    .irq_q    (period_irq)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_ev (step_ev),
    .cnt_nxt (cnt_nxt),
    .cmp_nxt (cmp_nxt),
    .flip    (ctl.flip),
    .phase_q (phase),
    .pin     (pwm_pin)
  );

  // R7: a saturated live compare always sits in the duty phase
  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '1) |-> phase);
  // R2: buffer writes alone never move the live compare
  assert_buf_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !(tick_en && ctl.run)) |=> $stable(cmp_act));
  // R5: a parked channel keeps its pin level while flip is unchanged
  assert_parked_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ctl.load && $stable(ctl.flip)) |=> $stable(pwm_pin));

endmodule

// File: tb/sim_pwm_buffered_chan.sv
module sim_pwm_buffered_chan;
  localparam int W  = 8;
  localparam int CW = 24;
  // slot 1 field at bits 8..11, slot 4 field at bits 20..23
  localparam int S1_RUN = 8, S1_LOAD = 9, S1_FLIP = 10, S1_RARM = 11;
  localparam int S4_RUN = 20, S4_LOAD = 21, S4_RARM = 22, S4_SPARE = 23;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic cnt_we = 1'b0, cmp_we = 1'b0;
  logic [W-1:0] cnt_wd = '0, cmp_wd = '0;
  logic [CW-1:0] ctrl = '0;
  logic pin0, irq0, pin1, irq1;
  int n_chk = 0, n_bad = 0;
  int lo0, hi0, irqc0, lo1, irqc1;

  always #10 clk = ~clk;

  pwm_buffered_chan #(.CNT_W(W), .CH_SLOT(1), .CTRL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_buf_we(cnt_we), .cnt_buf_wdata(cnt_wd),
    .cmp_buf_we(cmp_we), .cmp_buf_wdata(cmp_wd),
    .ctrl_word(ctrl), .pwm_pin(pin0), .period_irq(irq0));

  pwm_buffered_chan #(.CNT_W(W), .CH_SLOT(4), .CTRL_W(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_buf_we(cnt_we), .cnt_buf_wdata(cnt_wd),
    .cmp_buf_we(cmp_we), .cmp_buf_wdata(cmp_wd),
    .ctrl_word(ctrl), .pwm_pin(pin1), .period_irq(irq1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_bufs(input int c, input int m);
    cnt_we = 1'b1; cmp_we = 1'b1;
    cnt_wd = W'(c); cmp_wd = W'(m);
    cyc(1);
    cnt_we = 1'b0; cmp_we = 1'b0;
  endtask

  task automatic pulse(input int b);
    ctrl[b] = 1'b1;
    cyc(1);
    ctrl[b] = 1'b0;
  endtask

  task automatic measure(input int n, input bit toggle);
    lo0 = 0; hi0 = 0; irqc0 = 0; lo1 = 0; irqc1 = 0;
    for (int i = 0; i < n; i++) begin
      if (toggle) tick_en = ~tick_en;
      cyc(1);
      if (!pin0) lo0++; else hi0++;
      if (irq0) irqc0++;
      if (!pin1) lo1++;
      if (irq1) irqc1++;
    end
  endtask

  function automatic int lows_per_period(input int n, input int m);
    if (m == 255) return n + 1;
    if (m >= n) return 0;
    return n - m;
  endfunction

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R12 reset state
    check(pin0 == 1'b1, "R12 pin after reset", int'(pin0), 1);
    check(irq0 == 1'b0, "R12 irq after reset", int'(irq0), 0);
    check(pin1 == 1'b1, "R12 last-slot pin after reset", int'(pin1), 1);
    measure(8, 1'b0);
    check(irqc0 == 0, "R12 idle without run", irqc0, 0);

    // R1 R4 R6 R7 R8 sweep of period and compare, both polarities
    tick_en = 1'b1;
    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k <= n + 2; k++) begin
        for (int f = 0; f < 2; f++) begin
          automatic int m = (k == n + 2) ? 255 : k;
          automatic int exp_lo = 3 * lows_per_period(n, m);
          ctrl = '0;
          load_bufs(n, m);
          pulse(S1_LOAD);
          ctrl[S1_RUN] = 1'b1; ctrl[S1_RARM] = 1'b1; ctrl[S1_FLIP] = f[0];
          cyc(2 * (n + 1));
          measure(3 * (n + 1), 1'b0);
          check(irqc0 == 3, "R1 R4 interrupts per three periods", irqc0, 3);
          if (f == 0)
            check(lo0 == exp_lo, (m == 255) ? "R7 saturated compare low time" : "R6 low time",
                  lo0, exp_lo);
          else
            check(hi0 == exp_lo, "R8 flipped high time", hi0, exp_lo);
        end
      end
    end

    // R9 tick every other cycle doubles the period: N=3, compare 1
    ctrl = '0; tick_en = 1'b1;
    load_bufs(3, 1);
    pulse(S1_LOAD);
    ctrl[S1_RUN] = 1'b1; ctrl[S1_RARM] = 1'b1;
    measure(16, 1'b1);
    measure(24, 1'b1);
    check(irqc0 == 3, "R9 half-rate interrupts", irqc0, 3);
    check(lo0 == 12, "R9 half-rate low time", lo0, 12);
    tick_en = 1'b1;

    // R9 run clear: nothing moves (N=5 compare 2 -> pin low after load)
    ctrl = '0;
    load_bufs(5, 2);
    pulse(S1_LOAD);
    ctrl[S1_RARM] = 1'b1;
    measure(20, 1'b0);
    check(irqc0 == 0, "R9 no interrupt without run", irqc0, 0);
    check(lo0 == 20, "R9 pin frozen without run", lo0, 20);

    // R2 buffer writes do not leak; compare 7 would drive the pin high
    load_bufs(1, 7);
    measure(6, 1'b0);
    check(lo0 == 6, "R2 pin unchanged after buffer write", lo0, 6);
    pulse(S1_LOAD);
    check(pin0 == 1'b1, "R2 R3 pin after load", int'(pin0), 1);

    // R3 holding load suspends counting (N=3 compare 1 -> low)
    ctrl = '0;
    load_bufs(3, 1);
    ctrl[S1_LOAD] = 1'b1; ctrl[S1_RUN] = 1'b1; ctrl[S1_RARM] = 1'b1;
    measure(10, 1'b0);
    check(irqc0 == 0, "R3 no interrupt while load held", irqc0, 0);
    check(lo0 == 10, "R3 pin held while load held", lo0, 10);
    ctrl[S1_LOAD] = 1'b0;

    // R10 bits of other fields have no effect (slot 0 field and the gap)
    ctrl = '0;
    load_bufs(5, 2);
    pulse(S1_LOAD);
    ctrl[7:0] = 8'hFF;
    measure(20, 1'b0);
    check(irqc0 == 0, "R10 foreign bits no interrupt", irqc0, 0);
    check(lo0 == 20, "R10 foreign bits pin unchanged", lo0, 20);

    // R5 clearing re-arm ends after the current period and parks
    ctrl = '0;
    load_bufs(4, 1);
    pulse(S1_LOAD);
    ctrl[S1_RUN] = 1'b1; ctrl[S1_RARM] = 1'b1;
    cyc(7);
    ctrl[S1_RARM] = 1'b0;
    measure(30, 1'b0);
    check(irqc0 == 1, "R5 one final interrupt", irqc0, 1);
    measure(10, 1'b0);
    check(lo0 == 0, "R5 parked pin holds high", lo0, 0);
    check(irqc0 == 0, "R5 no interrupt while parked", irqc0, 0);
    ctrl[S1_RARM] = 1'b1;
    measure(10, 1'b0);
    check(irqc0 == 0, "R5 re-arm alone does not resume", irqc0, 0);
    pulse(S1_LOAD);
    ctrl[S1_RUN] = 1'b1; ctrl[S1_RARM] = 1'b1;
    cyc(5);
    measure(15, 1'b0);
    check(irqc0 == 3, "R3 R5 load resumes counting", irqc0, 3);

    // R11 last slot: re-arm at offset 2, offset 3 inert, no flip
    ctrl = '0;
    load_bufs(4, 1);
    pulse(S4_LOAD);
    ctrl[S4_RUN] = 1'b1; ctrl[S4_RARM] = 1'b1;
    cyc(10);
    measure(15, 1'b0);
    check(irqc1 == 3, "R11 last slot re-arms", irqc1, 3);
    check(lo1 == 9, "R11 last slot not inverted", lo1, 9);
    check(irqc0 == 0, "R10 slot 1 ignores last field", irqc0, 0);
    ctrl = '0;
    pulse(S4_LOAD);
    ctrl[S4_RUN] = 1'b1; ctrl[S4_SPARE] = 1'b1;
    measure(30, 1'b0);
    check(irqc1 == 1, "R11 offset 3 is not re-arm", irqc1, 1);
    check(pin1 == 1'b1, "R11 parked last slot pin", int'(pin1), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule